// File: doc/BRIEF.md
# Program/Erase Busy Status Engine

This block stands in for the busy phase of a flash array that has two banks, from the moment a program or erase has been accepted until it is done. A one-cycle start request carries the operation type, the target address and the word to program. While the operation runs, reads of the bank it occupies return status words instead of array contents. Reads of the other bank return the array word that the surrounding logic presents on `arr_rdata`. An active-low ready/busy output follows the internal operation. The busy time is a parameterised cycle count, not a model of the physical cells.

The address space splits at `BANK_SPLIT`. Addresses below it form the small bank (bank 0) and the rest form the large bank (bank 1). A word program, a sector erase or a block erase occupies only the bank that holds its address. A chip erase occupies both banks. Each operation has an active phase and then a short tail. During the tail the ready/busy output is already released, but the busy bank still answers with the final value instead of array data. The operation is then finished and normal reads resume. Holding the hardware reset input low for `RST_HOLD` consecutive cycles ends any operation at once.

Reads form a stream. A request (`rd_req` with `rd_addr` and `arr_rdata`) is taken every cycle it is high. Exactly one cycle later it produces one response (`rsp_valid`, `rsp_data`). There is no back-pressure: the consumer must take every response in the cycle it appears.

Top module: `flash_busy_status`

## Requirements
- R1: After `rst_n` is released, the block is idle: `ryby_n` is 1, `cmd_dropped` is 0, and a read returns `arr_rdata` unchanged.
- R2: Each cycle with `rd_req` high produces `rsp_valid` high in the next cycle, with the response in `rsp_data`. No request is ever stalled.
- R3: During the active phase of a word program (op code 2'b00), a read of the busy bank returns bit 7 equal to the complement of bit 7 of the programmed word. All bits other than 7 and 6 are 0.
- R4: During the active phase of an erase (op codes 2'b01 sector, 2'b10 block, 2'b11 chip), a read of a busy bank returns bit 7 equal to 0. All bits other than 7 and 6 are 0.
- R5: Bit 6 of a busy-bank read during the active phase reads 0 on the first such read after a start. It then inverts on every further busy-bank read. Reads of a bank that is not busy leave it unchanged.
- R6: While one bank is busy, a read of the other bank (bank 0 below `BANK_SPLIT`, bank 1 at or above it) returns `arr_rdata` unchanged.
- R7: A chip erase makes both banks busy. A program, sector erase or block erase makes only the bank of its address busy.
- R8: The active phase is followed by `TAIL_CYC` cycles of tail. During the tail, `ryby_n` is 1 and a busy-bank read returns the programmed word (program) or all ones (erase). After the tail, reads return `arr_rdata`.
- R9: `ryby_n` is 0 exactly during the active phase while `oe_n` and `ce_n` are 0 and `hw_rst_n` is 1. In every other case `ryby_n` is 1 (released).
- R10: Sampling `hw_rst_n` low on `RST_HOLD` consecutive clock edges ends the operation immediately, with no tail, and a new start is then accepted. A shorter low pulse has no effect on the operation.
- R11: A start during the active phase or the tail is ignored, and `cmd_dropped` is 1 in the following cycle. The running operation goes on unchanged.
- R12: The active phase lasts `PROG_CYC` cycles for a program, `SB_ERASE_CYC` for a sector or block erase and `CHIP_ERASE_CYC` for a chip erase, counted from the edge that accepts the start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| start | input | 1 | One-cycle request to begin an operation |
| start_op | input | 2 | Operation: 00 program, 01 sector erase, 10 block erase, 11 chip erase |
| start_addr | input | AW | Target word address |
| start_wdata | input | DW | Word to program |
| rd_req | input | 1 | Read request, taken every cycle it is high |
| rd_addr | input | AW | Read word address |
| arr_rdata | input | DW | Array word at `rd_addr`, valid with `rd_req` |
| oe_n | input | 1 | Output enable, active low |
| ce_n | input | 1 | Chip enable, active low |
| hw_rst_n | input | 1 | Hardware reset pin, active low |
| rsp_valid | output | 1 | Read response valid |
| rsp_data | output | DW | Read response word |
| ryby_n | output | 1 | Ready/busy, 0 = busy, 1 = ready or released |
| cmd_dropped | output | 1 | A start was ignored in the previous cycle |

## Verification
The bench programs two words whose bit 7 differs, so that the complemented status bit cannot be mistaken for a fixed value. It runs erases of every kind and reads the busy bank and the idle bank back to back, which separates status substitution, routing of the toggle bit and per-bank masking from plain pass-through. Counting busy cycles for each operation type shows which duration parameter applies to each op code. Reset pulses one cycle shorter than and exactly equal to `RST_HOLD` show where the abort threshold lies. A second start during a chip erase shows that the running operation survives a dropped command.

// File: rtl/fbs_pkg.sv
package fbs_pkg;
  typedef enum logic [1:0] {
    OP_PROG = 2'b00,
    OP_SECT = 2'b01,
    OP_BLK  = 2'b10,
    OP_CHIP = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'b00,
    PH_ACTIVE = 2'b01,
    PH_TAIL   = 2'b10
  } phase_e;
endpackage

// File: rtl/fbs_bank_sel.sv
module fbs_bank_sel #(
  parameter int AW = 20,
  parameter logic [AW-1:0] SPLIT = 20'h40000
) (
  input  logic [AW-1:0] addr,
  output logic [1:0]    bank_oh
);
  always_comb begin
    bank_oh = (addr < SPLIT) ? 2'b01 : 2'b10;
  end
endmodule

// File: rtl/fbs_timer.sv
module fbs_timer
  import fbs_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_last,
  input  logic [CW-1:0] tail_last,
  input  logic          abort,
  output phase_e        phase
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else if (abort) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (load) begin
            phase <= PH_ACTIVE;
            cnt   <= load_last;
          end
        end
        PH_ACTIVE: begin
          if (cnt == '0) begin
            phase <= PH_TAIL;
            cnt   <= tail_last;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_TAIL: begin
          if (cnt == '0) phase <= PH_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fbs_status_mux.sv
module fbs_status_mux
  import fbs_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_toggle,
  input  logic          rd_req,
  input  logic          rd_hit,
  input  phase_e        phase,
  input  logic          op_is_prog,
  input  logic [DW-1:0] prog_word,
  input  logic [DW-1:0] arr_rdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data
);
  logic          toggle_q;
  logic          flip;
  logic [DW-1:0] word_d;

  always_comb begin
    flip   = 1'b0;
    word_d = arr_rdata;
    if (rd_hit && phase == PH_ACTIVE) begin
      word_d    = '0;
      word_d[7] = op_is_prog ? ~prog_word[7] : 1'b0;
      word_d[6] = toggle_q;
      flip      = rd_req;
    end else if (rd_hit && phase == PH_TAIL) begin
      word_d = op_is_prog ? prog_word : '1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      toggle_q  <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      if (clr_toggle) toggle_q <= 1'b0;
      else if (flip)  toggle_q <= ~toggle_q;
      rsp_valid <= rd_req;
      if (rd_req) rsp_data <= word_d;
    end
  end
endmodule

// File: rtl/flash_busy_status.sv
module flash_busy_status
  import fbs_pkg::*;
#(
  parameter int AW             = 20,
  parameter int DW             = 16,
  parameter logic [AW-1:0] BANK_SPLIT = 20'h40000,
  parameter int PROG_CYC       = 200,
  parameter int SB_ERASE_CYC   = 1000,
  parameter int CHIP_ERASE_CYC = 4000,
  parameter int TAIL_CYC       = 20,
  parameter int RST_HOLD       = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    start_op,
  input  logic [AW-1:0] start_addr,
  input  logic [DW-1:0] start_wdata,
  input  logic          rd_req,
  input  logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] arr_rdata,
  input  logic          oe_n,
  input  logic          ce_n,
  input  logic          hw_rst_n,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          ryby_n,
  output logic          cmd_dropped
);
  localparam int MAXC1 = (PROG_CYC > SB_ERASE_CYC) ? PROG_CYC : SB_ERASE_CYC;
  localparam int MAXC2 = (MAXC1 > CHIP_ERASE_CYC) ? MAXC1 : CHIP_ERASE_CYC;
  localparam int MAXC  = (MAXC2 > TAIL_CYC) ? MAXC2 : TAIL_CYC;
  localparam int CW    = $clog2(MAXC + 1);
  localparam int HW    = $clog2(RST_HOLD + 1);
  localparam logic [CW-1:0] LAST_PROG = CW'(PROG_CYC - 1);
  localparam logic [CW-1:0] LAST_SB   = CW'(SB_ERASE_CYC - 1);
  localparam logic [CW-1:0] LAST_CHIP = CW'(CHIP_ERASE_CYC - 1);
  localparam logic [CW-1:0] LAST_TAIL = CW'(TAIL_CYC - 1);
  localparam logic [HW-1:0] HOLD_LAST = HW'(RST_HOLD - 1);

  phase_e        phase;
  logic          accept;
  logic          abort;
  logic [HW-1:0] hold_cnt;
  logic [1:0]    busy_mask;
  logic          op_is_prog;
  logic [DW-1:0] prog_word;
  logic [CW-1:0] load_last;
  logic [AW-1:0] sel_addr [2];
  logic [1:0]    sel_bank [2];
  logic          rd_hit;

  assign sel_addr[0] = start_addr;
  assign sel_addr[1] = rd_addr;

  for (genvar g = 0; g < 2; g++) begin : g_bank
    fbs_bank_sel #(.AW(AW), .SPLIT(BANK_SPLIT)) u_sel (
      .addr    (sel_addr[g]),
      .bank_oh (sel_bank[g])
    );
  end

  assign accept = start && (phase == PH_IDLE) && hw_rst_n;
  assign abort  = !hw_rst_n && (hold_cnt == HOLD_LAST);
  assign rd_hit = (phase != PH_IDLE) && ((sel_bank[1] & busy_mask) != 2'b00);

  always_comb begin
    unique case (op_e'(start_op))
      OP_PROG: load_last = LAST_PROG;
      OP_CHIP: load_last = LAST_CHIP;
      default: load_last = LAST_SB;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_cnt    <= '0;
      busy_mask   <= 2'b00;
      op_is_prog  <= 1'b0;
      prog_word   <= '0;
      cmd_dropped <= 1'b0;
    end else begin
      if (hw_rst_n)                  hold_cnt <= '0;
      else if (hold_cnt != HOLD_LAST) hold_cnt <= hold_cnt + 1'b1;
      cmd_dropped <= start && (phase != PH_IDLE);
      if (accept) begin
        busy_mask  <= (op_e'(start_op) == OP_CHIP) ? 2'b11 : sel_bank[0];
        op_is_prog <= (op_e'(start_op) == OP_PROG);
        prog_word  <= start_wdata;
      end else if (phase == PH_IDLE) begin
        busy_mask <= 2'b00;
      end
    end
  end

  fbs_timer #(.CW(CW)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_last (load_last),
    .tail_last (LAST_TAIL),
    .abort     (abort),
    .phase     (phase)
  );

  fbs_status_mux #(.DW(DW)) u_mux (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_toggle (accept),
    .rd_req     (rd_req),
    .rd_hit     (rd_hit),
    .phase      (phase),
    .op_is_prog (op_is_prog),
    .prog_word  (prog_word),
    .arr_rdata  (arr_rdata),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data)
  );

  assign ryby_n = !((phase == PH_ACTIVE) && !oe_n && !ce_n && hw_rst_n);
endmodule

// File: rtl/fbs_chk.sv
module fbs_chk
  import fbs_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       rd_req,
  input logic       rsp_valid,
  input logic       cmd_dropped,
  input logic       ryby_n,
  input logic       oe_n,
  input logic       ce_n,
  input logic       hw_rst_n,
  input phase_e     phase,
  input logic       abort,
  input logic [1:0] busy_mask
);
  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rsp_valid);

  // R11
  drop_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_dropped |-> $past(start));

  // R9
  busy_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ryby_n) && $stable(oe_n) && $stable(ce_n) && $stable(hw_rst_n)) |-> $past(start));

  // R8
  tail_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase) == PH_ACTIVE && phase == PH_IDLE) |-> $past(abort));

  // R10
  abort_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(abort) |-> phase == PH_IDLE);

  // R7
  mask_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE) |-> busy_mask != 2'b00);
endmodule

bind flash_busy_status fbs_chk u_fbs_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .rd_req      (rd_req),
  .rsp_valid   (rsp_valid),
  .cmd_dropped (cmd_dropped),
  .ryby_n      (ryby_n),
  .oe_n        (oe_n),
  .ce_n        (ce_n),
  .hw_rst_n    (hw_rst_n),
  .phase       (phase),
  .abort       (abort),
  .busy_mask   (busy_mask)
);

// File: tb/flash_busy_status_tb.sv
module flash_busy_status_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;
  localparam int DW = 16;
  localparam int T_PROG = 8;
  localparam int T_SB   = 12;
  localparam int T_CHIP = 16;
  localparam int T_TAIL = 3;
  localparam int T_HOLD = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] start_op = 2'b00;
  logic [AW-1:0] start_addr = '0;
  logic [DW-1:0] start_wdata = '0;
  logic rd_req = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] arr_rdata = '0;
  logic oe_n = 1'b0;
  logic ce_n = 1'b0;
  logic hw_rst_n = 1'b1;
  logic rsp_valid;
  logic [DW-1:0] rsp_data;
  logic ryby_n;
  logic cmd_dropped;

  int n_chk = 0;
  int n_fail = 0;
  logic [DW-1:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_busy_status #(
    .AW(AW), .DW(DW), .BANK_SPLIT(20'h40000),
    .PROG_CYC(T_PROG), .SB_ERASE_CYC(T_SB), .CHIP_ERASE_CYC(T_CHIP),
    .TAIL_CYC(T_TAIL), .RST_HOLD(T_HOLD)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .start_op(start_op),
    .start_addr(start_addr), .start_wdata(start_wdata), .rd_req(rd_req),
    .rd_addr(rd_addr), .arr_rdata(arr_rdata), .oe_n(oe_n), .ce_n(ce_n),
    .hw_rst_n(hw_rst_n), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .ryby_n(ryby_n), .cmd_dropped(cmd_dropped)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // monitor: pop expected responses as they appear
  always @(posedge clk) begin
    #1;
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        chk("R2 unexpected response", 32'(rsp_valid), 32'd0);
      end else begin
        automatic logic [DW-1:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(t, 32'(rsp_data), 32'(e));
      end
    end
  end

  // all tasks start and end at a falling edge
  task automatic do_start(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] w);
    start = 1'b1; start_op = op; start_addr = a; start_wdata = w;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] arr,
                         input logic [DW-1:0] exp, input string tag);
    rd_req = 1'b1; rd_addr = a; arr_rdata = arr;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic wait_active_end();
    for (int i = 0; i < 1000 && ryby_n == 1'b0; i++) @(negedge clk);
  endtask

  task automatic wait_idle();
    wait_active_end();
    repeat (T_TAIL + 1) @(negedge clk);
  endtask

  task automatic count_busy(input int exp, input string tag);
    int n = 0;
    while (ryby_n == 1'b0 && n < 1000) begin
      n++;
      @(negedge clk);
    end
    chk(tag, 32'(n), 32'(exp));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk("watchdog expired", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: idle after reset
    chk("R1 ryby_n after reset", 32'(ryby_n), 32'd1);
    chk("R1 cmd_dropped after reset", 32'(cmd_dropped), 32'd0);
    chk("R2 rsp_valid idle", 32'(rsp_valid), 32'd0);
    do_read(20'h00100, 16'h1111, 16'h1111, "R1 idle read");

    // program bank 0, data bit7 = 1
    do_start(2'b00, 20'h00100, 16'h00A5);
    do_read(20'h00100, 16'h7777, 16'h0000, "R3 program DQ7 complement");
    do_read(20'h00100, 16'h7777, 16'h0040, "R5 toggle second read");
    do_read(20'h50000, 16'h1234, 16'h1234, "R6 other bank during program");
    do_read(20'h00100, 16'h7777, 16'h0000, "R5 toggle third read");
    wait_active_end();
    chk("R8 ryby_n in tail", 32'(ryby_n), 32'd1);
    do_read(20'h00100, 16'h7777, 16'h00A5, "R8 program tail true data");
    repeat (T_TAIL + 1) @(negedge clk);
    do_read(20'h00100, 16'hBEEF, 16'hBEEF, "R8 normal read after tail");

    // program bank 1, data bit7 = 0
    do_start(2'b00, 20'h80000, 16'h0012);
    do_read(20'h80000, 16'h3333, 16'h0080, "R3 program DQ7 complement of 0");
    do_read(20'h00010, 16'h2468, 16'h2468, "R7 program leaves bank 0 free");
    wait_idle();

    // sector erase bank 1
    do_start(2'b01, 20'h60000, 16'h0000);
    do_read(20'h60000, 16'h9999, 16'h0000, "R4 erase DQ7 zero");
    do_read(20'h00200, 16'h5555, 16'h5555, "R6 bank 0 during bank 1 erase");
    do_read(20'h60000, 16'h9999, 16'h0040, "R5 toggle during erase");
    wait_active_end();
    do_read(20'h60000, 16'h9999, 16'hFFFF, "R8 erase tail all ones");
    repeat (T_TAIL + 1) @(negedge clk);

    // durations
    do_start(2'b00, 20'h00000, 16'h0000);
    count_busy(T_PROG, "R12 program length");
    repeat (T_TAIL + 1) @(negedge clk);
    do_start(2'b10, 20'h48000, 16'h0000);
    count_busy(T_SB, "R12 block erase length");
    repeat (T_TAIL + 1) @(negedge clk);
    do_start(2'b01, 20'h00400, 16'h0000);
    count_busy(T_SB, "R12 sector erase length");
    repeat (T_TAIL + 1) @(negedge clk);
    do_start(2'b11, 20'h00000, 16'h0000);
    count_busy(T_CHIP, "R12 chip erase length");
    repeat (T_TAIL + 1) @(negedge clk);

    // chip erase: both banks busy, drop, release, reset abort
    do_start(2'b11, 20'h00000, 16'h0000);
    do_read(20'h00000, 16'h1357, 16'h0000, "R7 chip erase bank 0 busy");
    do_read(20'h70000, 16'h1357, 16'h0040, "R7 chip erase bank 1 busy");
    do_start(2'b00, 20'h00000, 16'h00FF);
    chk("R11 cmd_dropped pulse", 32'(cmd_dropped), 32'd1);
    do_read(20'h70000, 16'h1357, 16'h0000, "R11 erase status unchanged after drop");
    chk("R11 cmd_dropped clears", 32'(cmd_dropped), 32'd0);
    oe_n = 1'b1; #1;
    chk("R9 released with oe_n high", 32'(ryby_n), 32'd1);
    oe_n = 1'b0; ce_n = 1'b1; #1;
    chk("R9 released with ce_n high", 32'(ryby_n), 32'd1);
    ce_n = 1'b0; #1;
    chk("R9 busy with enables low", 32'(ryby_n), 32'd0);
    hw_rst_n = 1'b0;
    repeat (T_HOLD - 1) @(negedge clk);
    hw_rst_n = 1'b1; #1;
    chk("R10 short reset pulse keeps operation", 32'(ryby_n), 32'd0);
    @(negedge clk);
    hw_rst_n = 1'b0; #1;
    chk("R9 released while reset low", 32'(ryby_n), 32'd1);
    @(negedge clk);
    repeat (T_HOLD - 1) @(negedge clk);
    hw_rst_n = 1'b1; #1;
    chk("R10 ryby_n after abort", 32'(ryby_n), 32'd1);
    @(negedge clk);
    do_read(20'h00000, 16'h4321, 16'h4321, "R10 no tail after abort");
    do_start(2'b00, 20'h00000, 16'h0000);
    count_busy(T_PROG, "R10 start accepted after abort");
    repeat (T_TAIL + 2) @(negedge clk);
    chk("R2 scoreboard drained", 32'(exp_q.size()), 32'd0);
    finish_run();
  end
endmodule